// File: doc/BRIEF.md
# Processor Status Flag Unit

This block computes results and keeps the status flags for a small integer datapath. Each cycle it takes two operands, a 3-bit operation code and a width select (8 or 16 bits). It returns the result without delay. When the flag-write enable is high, the clock edge captures six condition flags that describe that result: carry, auxiliary carry, overflow, sign, parity and zero.

Three control flags sit beside the condition flags: string direction, interrupt enable and single-step trap. Only explicit commands change them, and arithmetic leaves them alone. The interrupt-enable and trap bits are also driven straight to output pins. Interrupt delivery and the single-step trap sequence are handled elsewhere and use these pins.

All nine flags can be read as one 16-bit word. The same word can be loaded back, so the flag state can be saved and restored around a context switch.

Top module: `stat_flag_unit`

## Requirements
- R1: `op_code` selects the operation: 0 add, 1 add with carry-in, 2 subtract, 3 subtract with borrow-in, 4 AND, 5 OR, 6 XOR, 7 pass B. The carry-in and borrow-in come from the stored carry flag. With `op_wide`=0, only the low 8 bits of each operand are used and `result[15:8]` is 0. With `op_wide`=1, all 16 bits are used. `result` is combinational.
- R2: Carry is set when the selected width produces a carry out of its top bit, or a borrow into its top bit.
- R3: Auxiliary carry is set on a carry out of bit 3, or a borrow into bit 3. Overflow is set when the result of a signed add or subtract is out of range for the selected width.
- R4: Sign equals the top bit of the result at the selected width. Zero is set when the result is all zeros. Parity is set when the low 8 bits of the result hold an even number of ones. Parity uses only these 8 bits, at both widths.
- R5: The condition flags change only at a clock edge where `flag_we` is high. Otherwise they hold their value, but `result` is still produced.
- R6: AND, OR, XOR and pass B clear carry, overflow and auxiliary carry.
- R7: When `ctl_we` is high, the bit chosen by `ctl_sel` is written with `ctl_val`: 0 selects direction, 1 selects interrupt enable, 2 selects trap. A `ctl_sel` of 3 changes nothing. Add, subtract and logical operations never change these bits.
- R8: The bit positions in `flag_out` are: carry at bit 0, parity at bit 2, auxiliary carry at bit 4, zero at bit 6, sign at bit 7, trap at bit 8, interrupt enable at bit 9, direction at bit 10 and overflow at bit 11. Bit 1 always reads 1 and all other bits read 0. When `flag_ld` is high, the edge loads all nine flags from `flag_in` at the same positions. This load takes priority over `flag_we` and `ctl_we` in the same cycle.
- R9: `trap_req` always equals the stored trap flag and `int_en` always equals the stored interrupt-enable flag.
- R10: After reset, `flag_out` reads 0x0002.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_code | input | 3 | Operation select |
| op_wide | input | 1 | 1 = 16-bit, 0 = 8-bit operation |
| opnd_a | input | 16 | First operand (minuend) |
| opnd_b | input | 16 | Second operand (subtrahend) |
| flag_we | input | 1 | Capture condition flags of this operation |
| result | output | 16 | Operation result |
| ctl_we | input | 1 | Control-flag write command |
| ctl_sel | input | 2 | Control flag selected by the command |
| ctl_val | input | 1 | Value written to the selected control flag |
| flag_ld | input | 1 | Load the whole flag word |
| flag_in | input | 16 | Flag word to load |
| flag_out | output | 16 | Current flag word |
| trap_req | output | 1 | Single-step trap flag |
| int_en | output | 1 | Maskable interrupt enable flag |

## Verification
The clocked properties assume that every control input and operand is known and settled at each rising edge. They also assume that an operation is held steady for the whole cycle in which its flags are captured, because the flag properties compare the word after the edge with the result and inputs sampled at that edge. The bench meets both assumptions. It drives every input on the falling edge, holds it through the next rising edge, and starts with every input at zero while reset is asserted. Overlap of a word load with a flag write or a control command is applied on purpose, so that the load-priority property gets exercised.

// File: rtl/sfu_pkg.sv
package sfu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADC  = 3'd1,
    OP_SUB  = 3'd2,
    OP_SBB  = 3'd3,
    OP_AND  = 3'd4,
    OP_OR   = 3'd5,
    OP_XOR  = 3'd6,
    OP_PASS = 3'd7
  } sfu_op_e;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic aux;
    logic par;
    logic cry;
  } cond_t;

  localparam int FLAG_W  = 16;
  localparam int NIB_W   = 4;
  localparam int PAR_W   = 8;
  localparam int NCTL    = 3;

  localparam int POS_CRY = 0;
  localparam int POS_ONE = 1;
  localparam int POS_PAR = 2;
  localparam int POS_AUX = 4;
  localparam int POS_ZRO = 6;
  localparam int POS_SGN = 7;
  localparam int POS_TRP = 8;
  localparam int POS_IEN = 9;
  localparam int POS_DIR = 10;
  localparam int POS_OVF = 11;

  localparam logic [1:0] CSEL_DIR = 2'd0;
  localparam logic [1:0] CSEL_IEN = 2'd1;
  localparam logic [1:0] CSEL_TRP = 2'd2;

  localparam logic [FLAG_W-1:0] ONE_BIT  = FLAG_W'(1) << POS_ONE;
  localparam logic [FLAG_W-1:0] LD_MASK  =
    (FLAG_W'(1) << POS_CRY) | (FLAG_W'(1) << POS_PAR) | (FLAG_W'(1) << POS_AUX) |
    (FLAG_W'(1) << POS_ZRO) | (FLAG_W'(1) << POS_SGN) | (FLAG_W'(1) << POS_TRP) |
    (FLAG_W'(1) << POS_IEN) | (FLAG_W'(1) << POS_DIR) | (FLAG_W'(1) << POS_OVF);

  function automatic logic even_ones(input logic [PAR_W-1:0] v);
    return ~(^v);
  endfunction

  function automatic logic is_logical(input sfu_op_e op);
    return op[2];
  endfunction

  function automatic logic uses_carry_in(input sfu_op_e op);
    return (op == OP_ADC) || (op == OP_SBB);
  endfunction

  function automatic logic is_subtract(input sfu_op_e op);
    return (op == OP_SUB) || (op == OP_SBB);
  endfunction

  function automatic cond_t unpack_cond(input logic [FLAG_W-1:0] w);
    cond_t c;
    c.cry = w[POS_CRY];
    c.par = w[POS_PAR];
    c.aux = w[POS_AUX];
    c.zro = w[POS_ZRO];
    c.sgn = w[POS_SGN];
    c.ovf = w[POS_OVF];
    return c;
  endfunction

endpackage

// File: rtl/sfu_alu.sv
module sfu_alu
  import sfu_pkg::*;
#(
  parameter int WIDE_W   = 16,
  parameter int NARROW_W = 8
) (
  input  sfu_op_e           op,
  input  logic              wide,
  input  logic [WIDE_W-1:0] a,
  input  logic [WIDE_W-1:0] b,
  input  logic              cin,
  output logic [WIDE_W-1:0] res,
  output cond_t             flags,
  output logic              carry_top,
  output logic              carry_nib,
  output logic              signed_ovf
);

  localparam int NWID = 2;

  logic [NWID-1:0][WIDE_W-1:0] res_w;
  logic [NWID-1:0]             cy_w;
  logic [NWID-1:0]             ac_w;
  logic [NWID-1:0]             ov_w;
  logic                        arith;

  assign arith = ~is_logical(op);

  generate
    for (genvar g = 0; g < NWID; g++) begin : g_width
      localparam int W = (g == 0) ? NARROW_W : WIDE_W;
      logic [W-1:0] aw, bw, rw;
      logic [W:0]   ext;
      logic         c_in;
      logic         sign_a, sign_b, sign_r;

      always_comb begin
        aw   = a[W-1:0];
        bw   = b[W-1:0];
        c_in = uses_carry_in(op) ? cin : 1'b0;
        ext  = '0;
        unique case (op)
          OP_ADD, OP_ADC: ext = {1'b0, aw} + {1'b0, bw} + {{W{1'b0}}, c_in};
          OP_SUB, OP_SBB: ext = {1'b0, aw} - {1'b0, bw} - {{W{1'b0}}, c_in};
          OP_AND:         ext = {1'b0, aw & bw};
          OP_OR:          ext = {1'b0, aw | bw};
          OP_XOR:         ext = {1'b0, aw ^ bw};
          OP_PASS:        ext = {1'b0, bw};
        endcase
        rw = ext[W-1:0];
      end

      assign sign_a = aw[W-1];
      assign sign_b = bw[W-1];
      assign sign_r = rw[W-1];

      assign res_w[g] = WIDE_W'(rw);
      assign cy_w[g]  = arith & ext[W];
      assign ac_w[g]  = arith & (aw[NIB_W] ^ bw[NIB_W] ^ rw[NIB_W]);
      assign ov_w[g]  = arith & (sign_r != sign_a) &
                        (is_subtract(op) ? (sign_a != sign_b) : (sign_a == sign_b));
    end
  endgenerate

  assign res        = res_w[wide];
  assign carry_top  = cy_w[wide];
  assign carry_nib  = ac_w[wide];
  assign signed_ovf = ov_w[wide];

  always_comb begin
    flags.cry = carry_top;
    flags.aux = carry_nib;
    flags.ovf = signed_ovf;
    flags.sgn = wide ? res[WIDE_W-1] : res[NARROW_W-1];
    flags.zro = (res == '0);
    flags.par = even_ones(res[PAR_W-1:0]);
  end

endmodule

// File: rtl/sfu_cond_reg.sv
module sfu_cond_reg
  import sfu_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  upd_en,
  input  cond_t upd_val,
  input  logic  ld_en,
  input  cond_t ld_val,
  output cond_t q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (ld_en)  q <= ld_val;
    else if (upd_en) q <= upd_val;
  end

  // R5: no capture request means the condition flags keep their value
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_en && !ld_en) |=> $stable(q));

endmodule

// File: rtl/sfu_ctl_reg.sv
module sfu_ctl_reg
  import sfu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_en,
  input  logic [1:0]      cmd_sel,
  input  logic            cmd_val,
  input  logic            ld_en,
  input  logic [NCTL-1:0] ld_val,
  output logic [NCTL-1:0] q
);

  generate
    for (genvar g = 0; g < NCTL; g++) begin : g_bit
      logic hit;
      assign hit = cmd_en && (cmd_sel == 2'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q[g] <= 1'b0;
        else if (ld_en) q[g] <= ld_val[g];
        else if (hit)   q[g] <= cmd_val;
      end
    end
  endgenerate

  // R7: control flags move only on a command or a full-word load
  p_ctl_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_en && !ld_en) |=> $stable(q));

  // R7: an unused selector leaves every control flag alone
  p_ctl_unused_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_en && cmd_sel == 2'd3 && !ld_en) |=> $stable(q));

endmodule

// File: rtl/stat_flag_unit.sv
module stat_flag_unit
  import sfu_pkg::*;
#(
  parameter int WIDE_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_code,
  input  logic              op_wide,
  input  logic [WIDE_W-1:0] opnd_a,
  input  logic [WIDE_W-1:0] opnd_b,
  input  logic              flag_we,
  output logic [WIDE_W-1:0] result,
  input  logic              ctl_we,
  input  logic [1:0]        ctl_sel,
  input  logic              ctl_val,
  input  logic              flag_ld,
  input  logic [FLAG_W-1:0] flag_in,
  output logic [FLAG_W-1:0] flag_out,
  output logic              trap_req,
  output logic              int_en
);

  sfu_op_e         op_e;
  cond_t           alu_flags;
  cond_t           cond_q;
  cond_t           cond_ld;
  logic [NCTL-1:0] ctl_q;
  logic [NCTL-1:0] ctl_ld;
  logic            carry_top, carry_nib, signed_ovf;

  assign op_e = sfu_op_e'(op_code);

  sfu_alu #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_alu (
    .op         (op_e),
    .wide       (op_wide),
    .a          (opnd_a),
    .b          (opnd_b),
    .cin        (cond_q.cry),
    .res        (result),
    .flags      (alu_flags),
    .carry_top  (carry_top),
    .carry_nib  (carry_nib),
    .signed_ovf (signed_ovf)
  );

  assign cond_ld = unpack_cond(flag_in);

  sfu_cond_reg u_cond (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_en  (flag_we),
    .upd_val (alu_flags),
    .ld_en   (flag_ld),
    .ld_val  (cond_ld),
    .q       (cond_q)
  );

  always_comb begin
    ctl_ld           = '0;
    ctl_ld[CSEL_DIR] = flag_in[POS_DIR];
    ctl_ld[CSEL_IEN] = flag_in[POS_IEN];
    ctl_ld[CSEL_TRP] = flag_in[POS_TRP];
  end

  sfu_ctl_reg u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_en  (ctl_we),
    .cmd_sel (ctl_sel),
    .cmd_val (ctl_val),
    .ld_en   (flag_ld),
    .ld_val  (ctl_ld),
    .q       (ctl_q)
  );

  always_comb begin
    flag_out          = '0;
    flag_out[POS_ONE] = 1'b1;
    flag_out[POS_CRY] = cond_q.cry;
    flag_out[POS_PAR] = cond_q.par;
    flag_out[POS_AUX] = cond_q.aux;
    flag_out[POS_ZRO] = cond_q.zro;
    flag_out[POS_SGN] = cond_q.sgn;
    flag_out[POS_OVF] = cond_q.ovf;
    flag_out[POS_TRP] = ctl_q[CSEL_TRP];
    flag_out[POS_IEN] = ctl_q[CSEL_IEN];
    flag_out[POS_DIR] = ctl_q[CSEL_DIR];
  end

  assign trap_req = ctl_q[CSEL_TRP];
  assign int_en   = ctl_q[CSEL_IEN];

  // R6: logical operations leave carry, overflow and auxiliary carry cleared
  p_logic_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && !flag_ld && op_code[2]) |=>
      (!flag_out[POS_CRY] && !flag_out[POS_OVF] && !flag_out[POS_AUX]));

  // R3: a narrow add of operands with different signs never overflows
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && !flag_ld && !op_wide && op_code[2:1] == 2'b00 &&
     opnd_a[NARROW_W-1] != opnd_b[NARROW_W-1]) |=> !flag_out[POS_OVF]);

  // R4: zero flag captured from the result of the same cycle
  p_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && !flag_ld) |=> (flag_out[POS_ZRO] == ($past(result) == '0)));

  // R4: parity over the low byte of the result
  p_parity_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && !flag_ld) |=> (flag_out[POS_PAR] == ~(^$past(result[PAR_W-1:0]))));

  // R4: sign taken from the top bit of the selected width
  p_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && !flag_ld) |=>
      (flag_out[POS_SGN] == $past(op_wide ? result[WIDE_W-1] : result[NARROW_W-1])));

  // R8: a word load wins and reads back through the fixed mask
  p_word_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_ld |=> (flag_out == (($past(flag_in) & LD_MASK) | ONE_BIT)));

  // R1: narrow operations never drive the upper byte
  p_narrow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !op_wide |-> (result[WIDE_W-1:NARROW_W] == '0));

endmodule

// File: tb/stat_flag_unit_tb.sv
module stat_flag_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_code = '0;
  logic        op_wide = 1'b0;
  logic [15:0] opnd_a = '0, opnd_b = '0;
  logic        flag_we = 1'b0;
  logic [15:0] result;
  logic        ctl_we = 1'b0;
  logic [1:0]  ctl_sel = '0;
  logic        ctl_val = 1'b0;
  logic        flag_ld = 1'b0;
  logic [15:0] flag_in = '0;
  logic [15:0] flag_out;
  logic        trap_req, int_en;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  logic [15:0] exp_word;

  always #(CLK_PERIOD/2) clk = ~clk;

  stat_flag_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .op_wide(op_wide),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .flag_we(flag_we), .result(result),
    .ctl_we(ctl_we), .ctl_sel(ctl_sel), .ctl_val(ctl_val),
    .flag_ld(flag_ld), .flag_in(flag_in), .flag_out(flag_out),
    .trap_req(trap_req), .int_en(int_en)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  // Independent integer model of one operation.
  task automatic model(input logic [2:0] op, input logic wide, input logic [15:0] a,
                       input logic [15:0] b, input logic cin,
                       output logic [15:0] r, output logic [15:0] fw);
    int m, half, ua, ub, sa, sb, c, full, s, ones;
    logic cf, af, of, sf, zf, pf;
    m    = wide ? 65535 : 255;
    half = (m + 1) / 2;
    ua = int'(a) & m;  ub = int'(b) & m;
    sa = (ua >= half) ? ua - (m + 1) : ua;
    sb = (ub >= half) ? ub - (m + 1) : ub;
    c  = (op == 3'd1 || op == 3'd3) ? int'(cin) : 0;
    cf = 0; af = 0; of = 0; full = 0;
    case (op)
      3'd0, 3'd1: begin
        full = ua + ub + c; cf = full > m;
        af = ((ua % 16) + (ub % 16) + c) > 15;
        s = sa + sb + c; of = (s >= half) || (s < -half);
      end
      3'd2, 3'd3: begin
        full = ua - ub - c; cf = full < 0;
        af = ((ua % 16) - (ub % 16) - c) < 0;
        s = sa - sb - c; of = (s >= half) || (s < -half);
      end
      3'd4: full = ua & ub;
      3'd5: full = ua | ub;
      3'd6: full = ua ^ ub;
      default: full = ub;
    endcase
    r  = 16'(full & m);
    sf = wide ? r[15] : r[7];
    zf = (r == 16'h0);
    ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(r[i]);
    pf = (ones % 2) == 0;
    fw = 16'h0002 | (16'(cf)) | (16'(pf) << 2) | (16'(af) << 4) |
         (16'(zf) << 6) | (16'(sf) << 7) | (16'(of) << 11);
  endtask

  // Drive one operation at a falling edge, check result, then the word.
  task automatic run_op(input string tag, input logic [2:0] op, input logic wide,
                        input logic [15:0] a, input logic [15:0] b, input logic we);
    logic [15:0] er, ef;
    model(op, wide, a, b, exp_word[0], er, ef);
    op_code = op; op_wide = wide; opnd_a = a; opnd_b = b; flag_we = we;
    #1;
    check({tag, " result"}, result, er);
    @(posedge clk);
    @(negedge clk);
    flag_we = 1'b0;
    if (we) exp_word = (exp_word & 16'h0700) | ef;
    check({tag, " flags"}, flag_out, exp_word);
  endtask

  task automatic ctl_cmd(input string tag, input logic [1:0] sel, input logic val);
    ctl_we = 1'b1; ctl_sel = sel; ctl_val = val;
    @(posedge clk);
    @(negedge clk);
    ctl_we = 1'b0;
    case (sel)
      2'd0: exp_word[10] = val;
      2'd1: exp_word[9]  = val;
      2'd2: exp_word[8]  = val;
      default: ;
    endcase
    check(tag, flag_out, exp_word);
    check({tag, " pins R9"}, {14'h0, trap_req, int_en}, {14'h0, exp_word[8], exp_word[9]});
  endtask

  task automatic load_word(input string tag, input logic [15:0] w, input logic also_ops);
    flag_ld = 1'b1; flag_in = w;
    if (also_ops) begin
      flag_we = 1'b1; op_code = 3'd0; op_wide = 1'b0; opnd_a = 16'h00FF; opnd_b = 16'h0001;
      ctl_we = 1'b1; ctl_sel = 2'd1; ctl_val = ~w[9];
    end
    @(posedge clk);
    @(negedge clk);
    flag_ld = 1'b0; flag_we = 1'b0; ctl_we = 1'b0;
    exp_word = (w & 16'h0FD5) | 16'h0002;
    check(tag, flag_out, exp_word);
  endtask

  task automatic t_reset;
    check("R10 reset word", flag_out, 16'h0002);
    check("R9 reset pins", {14'h0, trap_req, int_en}, 16'h0);
  endtask

  task automatic t_add;
    run_op("R3 add8 7F+01", 3'd0, 1'b0, 16'h007F, 16'h0001, 1'b1);
    run_op("R2 add8 FF+01", 3'd0, 1'b0, 16'h00FF, 16'h0001, 1'b1);
    run_op("R1 add8 upper ignored", 3'd0, 1'b0, 16'h12FF, 16'h3401, 1'b1);
    run_op("R2 add16 FFFF+1", 3'd0, 1'b1, 16'hFFFF, 16'h0001, 1'b1);
    run_op("R3 add16 7FFF+1", 3'd0, 1'b1, 16'h7FFF, 16'h0001, 1'b1);
    run_op("R4 add16 parity low byte", 3'd0, 1'b1, 16'h0100, 16'h0203, 1'b1);
  endtask

  task automatic t_sub;
    run_op("R2 sub8 00-01", 3'd2, 1'b0, 16'h0000, 16'h0001, 1'b1);
    run_op("R3 sub8 80-01", 3'd2, 1'b0, 16'h0080, 16'h0001, 1'b1);
    run_op("R3 sub16 8000-1", 3'd2, 1'b1, 16'h8000, 16'h0001, 1'b1);
    run_op("R4 sub16 equal", 3'd2, 1'b1, 16'h1234, 16'h1234, 1'b1);
  endtask

  task automatic t_carry_chain;
    run_op("R1 set carry", 3'd0, 1'b0, 16'h00F0, 16'h0020, 1'b1);
    run_op("R1 adc uses carry", 3'd1, 1'b0, 16'h0001, 16'h0001, 1'b1);
    run_op("R1 sub make borrow", 3'd2, 1'b1, 16'h0001, 16'h0002, 1'b1);
    run_op("R1 sbb uses borrow", 3'd3, 1'b1, 16'h0010, 16'h0001, 1'b1);
    run_op("R2 adc ripple", 3'd1, 1'b0, 16'h00FF, 16'h0000, 1'b1);
  endtask

  task automatic t_logic;
    run_op("R6 prime flags", 3'd0, 1'b0, 16'h00FF, 16'h00FF, 1'b1);
    run_op("R6 and clears", 3'd4, 1'b0, 16'h00F0, 16'h000F, 1'b1);
    run_op("R6 or", 3'd5, 1'b1, 16'h8000, 16'h0001, 1'b1);
    run_op("R6 xor", 3'd6, 1'b0, 16'h00AA, 16'h0055, 1'b1);
    run_op("R1 pass b", 3'd7, 1'b1, 16'hFFFF, 16'h0000, 1'b1);
  endtask

  task automatic t_hold;
    run_op("R5 set state", 3'd0, 1'b0, 16'h0080, 16'h0080, 1'b1);
    run_op("R5 no write add", 3'd0, 1'b1, 16'h0001, 16'h0001, 1'b0);
    run_op("R5 no write and", 3'd4, 1'b0, 16'h0000, 16'h0000, 1'b0);
  endtask

  task automatic t_ctl;
    ctl_cmd("R7 set dir", 2'd0, 1'b1);
    ctl_cmd("R7 set ien", 2'd1, 1'b1);
    ctl_cmd("R7 set trap", 2'd2, 1'b1);
    ctl_cmd("R7 unused sel", 2'd3, 1'b0);
    run_op("R7 arith keeps ctl", 3'd2, 1'b0, 16'h0000, 16'h0001, 1'b1);
    run_op("R7 logic keeps ctl", 3'd6, 1'b1, 16'hFFFF, 16'hFFFF, 1'b1);
    ctl_cmd("R7 clear ien", 2'd1, 1'b0);
    ctl_cmd("R7 clear trap", 2'd2, 1'b0);
  endtask

  task automatic t_word;
    load_word("R8 load all ones", 16'hFFFF, 1'b0);
    check("R9 pins after load", {14'h0, trap_req, int_en}, 16'h0003);
    load_word("R8 load zero with ops", 16'h0000, 1'b1);
    load_word("R8 load pattern", 16'h0A51, 1'b0);
    run_op("R1 adc from loaded carry", 3'd1, 1'b1, 16'h0000, 16'h0000, 1'b1);
  endtask

  initial begin
    exp_word = 16'h0002;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_add();
    t_sub();
    t_carry_chain();
    t_logic();
    t_hold();
    t_ctl();
    t_word();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule